// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Unit

This unit joins two eight-line priority resolvers, a master and a slave, into one sixteen-line interrupt system. It does not resolve priority itself. Each resolver reports whether it has a winning request and which line wins. From those reports the unit drives the cascade input of the master, raises the interrupt request to the processor, answers an acknowledge strobe with an 8-bit vector and sends acknowledge strobes back to the resolver cores.

It also handles the cases where a request disappears. If the master picks its cascade line but the slave has nothing pending, the unit tells the master to clear that phantom request so that lower-priority master lines can win. If a request vanishes before the acknowledge arrives, the unit returns a fixed spurious vector for that controller. If a mask write hides the current winner, the unit withdraws the processor request at once instead of waiting for the resolvers to settle.

Each vector base supplies only the upper five bits of the vector. The lower three bits always come from the line number.

Top module: `cascade_ack_unit`

## Requirements
- R1: `casc_req` equals `s_pend` in the same cycle, with no register in between.
- R2: When the master reports line 2 as its winner while `s_pend` is low, `m_irr2_clr` is high in that cycle and `cpu_int` is low in the next cycle. Once the master reports a different line, `cpu_int` rises again one cycle later.
- R3: After any cycle in which `m_pend` is high with a real winner, no acknowledge and no masking write, `cpu_int` is high. After a cycle with `m_pend` low, `cpu_int` is low.
- R4: An acknowledge while the master winner is a line other than 2 raises `m_ack` with `m_ack_line` equal to that line in the same cycle. On the next cycle `vec` is {`m_base`, line}: the base fills bits 7:3 and the line fills bits 2:0.
- R5: An acknowledge while the master winner is line 2 and the slave has a pending request raises both `m_ack` (line 2) and `s_ack` (the slave line). On the next cycle `vec` is {`s_base`, slave line}.
- R6: An acknowledge while the master winner is line 2 and the slave has nothing pending raises `m_ack` but not `s_ack`. On the next cycle `vec` is {`s_base`, 3'd7}.
- R7: An acknowledge while the master has nothing pending raises neither `m_ack` nor `s_ack`. On the next cycle `vec` is {`m_base`, 3'd7}.
- R8: `vec_valid` is high for exactly the one cycle after each acknowledge strobe. At all other times `vec` keeps its last value.
- R9: A master mask write (`mask_sel`=0) whose bit for the current master winner (a line other than 2) is set forces `cpu_int` low in the next cycle and leaves `m_irr2_clr` low.
- R10: A slave mask write (`mask_sel`=1) whose bit for the current slave winner is set, while the master winner is line 2, raises `m_irr2_clr` in that cycle and forces `cpu_int` low in the next cycle.
- R11: A mask write that does not set the bit of the current winner on that winner's controller leaves `cpu_int` high.
- R12: After reset `cpu_int`, `vec_valid` and `vec` are all zero.
- R13: `cpu_int` is low in the cycle after an acknowledge strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_pend | input | 1 | Master resolver has a winner |
| m_line | input | 3 | Master winning line |
| s_pend | input | 1 | Slave resolver has a winner |
| s_line | input | 3 | Slave winning line |
| m_base | input | 5 | Master vector base, vector bits 7:3 |
| s_base | input | 5 | Slave vector base, vector bits 7:3 |
| inta_req | input | 1 | Single-cycle acknowledge strobe from the processor |
| mask_wr | input | 1 | Mask write strobe |
| mask_sel | input | 1 | Target of the mask write: 0 master, 1 slave |
| mask_val | input | 8 | New mask value, bit n masks line n |
| casc_req | output | 1 | Drives master input line 2 |
| m_irr2_clr | output | 1 | Tells the master to clear its line-2 request |
| m_ack | output | 1 | Acknowledge strobe to the master core |
| m_ack_line | output | 3 | Line acknowledged on the master |
| s_ack | output | 1 | Acknowledge strobe to the slave core |
| s_ack_line | output | 3 | Line acknowledged on the slave |
| cpu_int | output | 1 | Interrupt request to the processor |
| vec | output | 8 | Vector returned for the last acknowledge |
| vec_valid | output | 1 | `vec` is fresh this cycle |

## Verification
The acknowledge path is driven with each of the four resolver situations it can meet: a plain master line, a line-2 winner backed by a slave request, a line-2 winner with an empty slave, and an empty master. Each one produces a different vector base, a different low field and a different set of acknowledge strobes. The two vector bases are given distinct values so that a vector taken from the wrong base shows up. Mask writes are tried against the master winner, against the slave winner, and against lines that are not the winner. This separates a dropped request from one that stays up, and shows whether the line-2 clear pulse is tied to the slave case only. A phantom line-2 winner followed by a real master line checks both the clear pulse and the return of the processor request.

// File: rtl/cascade_ack_unit.sv
module cascade_ack_unit #(
  parameter int LINES     = 8,
  parameter int CASC_LINE = 2,
  parameter int VEC_W     = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          m_pend,
  input  logic [$clog2(LINES)-1:0]      m_line,
  input  logic                          s_pend,
  input  logic [$clog2(LINES)-1:0]      s_line,
  input  logic [VEC_W-$clog2(LINES)-1:0] m_base,
  input  logic [VEC_W-$clog2(LINES)-1:0] s_base,
  input  logic                          inta_req,
  input  logic                          mask_wr,
  input  logic                          mask_sel,
  input  logic [LINES-1:0]              mask_val,
  output logic                          casc_req,
  output logic                          m_irr2_clr,
  output logic                          m_ack,
  output logic [$clog2(LINES)-1:0]      m_ack_line,
  output logic                          s_ack,
  output logic [$clog2(LINES)-1:0]      s_ack_line,
  output logic                          cpu_int,
  output logic [VEC_W-1:0]              vec,
  output logic                          vec_valid
);
  localparam int LW = $clog2(LINES);
  localparam logic [LW-1:0] CASC  = LW'(CASC_LINE);
  localparam logic [LW-1:0] SPUR  = LW'(LINES - 1);

  logic via_slave, phantom, kill_master, kill_slave, deliver;
  logic [VEC_W-1:0] vec_next;

  assign casc_req    = s_pend;
  assign via_slave   = m_pend && (m_line == CASC);
  assign phantom     = via_slave && !s_pend;
  assign kill_master = mask_wr && !mask_sel && m_pend && !via_slave && mask_val[m_line];
  assign kill_slave  = mask_wr && mask_sel && via_slave && s_pend && mask_val[s_line];
  assign m_irr2_clr  = phantom || kill_slave;
  assign deliver     = m_pend && !phantom && !kill_master && !kill_slave && !inta_req;

  assign m_ack      = inta_req && m_pend;
  assign m_ack_line = m_line;
  assign s_ack      = inta_req && via_slave && s_pend;
  assign s_ack_line = s_line;

  always_comb begin
    if (!m_pend)        vec_next = {m_base, SPUR};
    else if (!via_slave) vec_next = {m_base, m_line};
    else if (s_pend)    vec_next = {s_base, s_line};
    else                vec_next = {s_base, SPUR};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_int   <= 1'b0;
      vec       <= '0;
      vec_valid <= 1'b0;
    end else begin
      cpu_int   <= deliver;
      vec_valid <= inta_req;
      if (inta_req) vec <= vec_next;
    end
  end

  AST_VEC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    inta_req |=> vec_valid);  // R8
  AST_MASTER_SPUR: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_req && !m_pend) |=> (vec[LW-1:0] == SPUR && vec[VEC_W-1:LW] == $past(m_base)));  // R7
  AST_SLAVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_req && m_pend && m_line == CASC) |=> (vec[VEC_W-1:LW] == $past(s_base)));  // R5
  AST_PHANTOM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (m_pend && m_line == CASC && !s_pend) |=> !cpu_int);  // R2
  AST_MASK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !mask_sel && m_pend && m_line != CASC && mask_val[m_line]) |=> !cpu_int);  // R9
  AST_ACK_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    inta_req |=> !cpu_int);  // R13
endmodule

// File: tb/test_cascade_ack_unit.sv
module test_cascade_ack_unit;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic m_pend = 0, s_pend = 0, inta_req = 0, mask_wr = 0, mask_sel = 0;
  logic [2:0] m_line = 0, s_line = 0;
  logic [4:0] m_base = 5'h04, s_base = 5'h0E;
  logic [7:0] mask_val = 0;
  logic casc_req, m_irr2_clr, m_ack, s_ack, cpu_int, vec_valid;
  logic [2:0] m_ack_line, s_ack_line;
  logic [7:0] vec;
  int tests = 0, fails = 0;
  bit done = 0;

  cascade_ack_unit i_cascade_ack_unit (
    .clk(clk), .rst_n(rst_n), .m_pend(m_pend), .m_line(m_line),
    .s_pend(s_pend), .s_line(s_line), .m_base(m_base), .s_base(s_base),
    .inta_req(inta_req), .mask_wr(mask_wr), .mask_sel(mask_sel), .mask_val(mask_val),
    .casc_req(casc_req), .m_irr2_clr(m_irr2_clr), .m_ack(m_ack), .m_ack_line(m_ack_line),
    .s_ack(s_ack), .s_ack_line(s_ack_line), .cpu_int(cpu_int), .vec(vec), .vec_valid(vec_valid));

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    m_pend = 0; s_pend = 0; inta_req = 0; mask_wr = 0; mask_sel = 0; mask_val = 0;
    cyc();
  endtask

  task automatic t_reset();
    chk("R12 cpu_int", cpu_int, 0);
    chk("R12 vec_valid", vec_valid, 0);
    chk("R12 vec", vec, 0);
  endtask

  task automatic t_cascade();
    s_pend = 1; #1 chk("R1 casc high", casc_req, 1);
    s_pend = 0; #1 chk("R1 casc low", casc_req, 0);
    cyc();
  endtask

  task automatic t_master_line();
    m_pend = 1; m_line = 5; cyc();
    chk("R3 int up", cpu_int, 1);
    inta_req = 1; #1
    chk("R4 m_ack", m_ack, 1);
    chk("R4 m_ack_line", m_ack_line, 5);
    chk("R4 no s_ack", s_ack, 0);
    cyc(); inta_req = 0;
    chk("R4 vec", vec, 8'h25);
    chk("R8 valid", vec_valid, 1);
    chk("R13 int drop", cpu_int, 0);
    m_pend = 0; cyc();
    chk("R8 valid pulse", vec_valid, 0);
    chk("R8 vec held", vec, 8'h25);
    chk("R3 int low", cpu_int, 0);
  endtask

  task automatic t_slave_line();
    m_pend = 1; m_line = 2; s_pend = 1; s_line = 3; cyc();
    chk("R3 int via slave", cpu_int, 1);
    inta_req = 1; #1
    chk("R5 m_ack", m_ack, 1);
    chk("R5 m_ack_line", m_ack_line, 2);
    chk("R5 s_ack", s_ack, 1);
    chk("R5 s_ack_line", s_ack_line, 3);
    cyc(); inta_req = 0;
    chk("R5 vec", vec, 8'h73);
    idle();
  endtask

  task automatic t_slave_spur();
    m_pend = 1; m_line = 2; s_pend = 0; inta_req = 1; #1
    chk("R6 m_ack", m_ack, 1);
    chk("R6 no s_ack", s_ack, 0);
    cyc(); inta_req = 0;
    chk("R6 vec", vec, 8'h77);
    idle();
  endtask

  task automatic t_master_spur();
    m_pend = 0; inta_req = 1; #1
    chk("R7 no m_ack", m_ack, 0);
    chk("R7 no s_ack", s_ack, 0);
    cyc(); inta_req = 0;
    chk("R7 vec", vec, 8'h27);
    chk("R8 valid spur", vec_valid, 1);
    idle();
  endtask

  task automatic t_phantom();
    m_pend = 1; m_line = 2; s_pend = 0; #1
    chk("R2 clr", m_irr2_clr, 1);
    cyc();
    chk("R2 no int", cpu_int, 0);
    m_line = 6; #1
    chk("R2 clr gone", m_irr2_clr, 0);
    cyc();
    chk("R2 int back", cpu_int, 1);
    idle();
  endtask

  task automatic t_mask_master();
    m_pend = 1; m_line = 5; cyc();
    mask_wr = 1; mask_sel = 0; mask_val = 8'h20; #1
    chk("R9 no clr", m_irr2_clr, 0);
    cyc(); mask_wr = 0;
    chk("R9 int drop", cpu_int, 0);
    idle();
  endtask

  task automatic t_mask_slave();
    m_pend = 1; m_line = 2; s_pend = 1; s_line = 4; cyc();
    chk("R10 int before", cpu_int, 1);
    mask_wr = 1; mask_sel = 1; mask_val = 8'h10; #1
    chk("R10 clr", m_irr2_clr, 1);
    cyc(); mask_wr = 0;
    chk("R10 int drop", cpu_int, 0);
    idle();
  endtask

  task automatic t_mask_other();
    m_pend = 1; m_line = 5; cyc();
    mask_wr = 1; mask_sel = 0; mask_val = 8'hDF; cyc();
    chk("R11 other lines", cpu_int, 1);
    mask_sel = 1; mask_val = 8'h20; cyc();
    chk("R11 wrong controller", cpu_int, 1);
    idle();
  endtask

  initial begin
    #(PERIOD*200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    t_reset();
    rst_n = 1; cyc();
    t_cascade();
    t_master_line();
    t_slave_line();
    t_slave_spur();
    t_master_spur();
    t_phantom();
    t_mask_master();
    t_mask_slave();
    t_mask_other();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule